// File: doc/BRIEF.md
# Legacy display access trap generator

This block sits beside a memory and I/O access bus and raises a one-cycle system-management interrupt request whenever software touches one of the legacy display address windows that has been armed. Display emulation code can then take over the access. Three memory windows and three I/O port windows each have their own enable bit. A 32-bit slice mask can exempt 2 KB pieces of the main graphics window, so that accesses to off-screen buffers do not interrupt.

Software reaches the registers through an indexed byte port. It first writes an index, then reads or writes the data byte that the index selects. Each trapped access leaves its address, its direction and a memory/I/O flag in a status record. That record is held unchanged until software clears it.

Top module: `legacy_disp_trap`

## Requirements
- R1: After reset the control byte (index 0xB9) reads 0x00, the status byte at index 0xC2 reads 0x00 and trap_irq is low. No access traps until software sets an enable.
- R2: Control bits 0, 1 and 2 enable the memory windows 0xA0000–0xAFFFF, 0xB0000–0xB7FFF and 0xB8000–0xBFFFF, respectively. A memory access (acc_valid=1, acc_is_mem=1) inside an enabled window drives trap_irq high for exactly the following cycle, for both reads and writes.
- R3: Control bits 3, 4 and 5 enable the port windows 0x3B0–0x3BF, 0x3C0–0x3CF and 0x3D0–0x3DF, respectively. An I/O access (acc_is_mem=0) is decoded on acc_addr[15:0] only, so acc_addr[19:16] are ignored.
- R4: Mask bit n exempts memory addresses 0xA0000+n·0x800 through 0xA07FF+n·0x800 from trapping. When bit n is clear, a hit in the enabled 0xA0000 window traps.
- R5: The mask has no effect on any other window. With no memory enable set, the mask changes no interrupt.
- R6: The four mask bytes sit at indices 0xBA–0xBD, least significant byte first, and read back as written. Control bits 7:6 always read 0.
- R7: An index outside 0xB9–0xBD and 0xC0–0xC2 reads 0x00. A data write to such an index changes no register.
- R8: A trap while no status is held latches the status. Index 0xC0 gives addr[7:0], index 0xC1 gives addr[15:8], and index 0xC2 gives {held, is_mem, is_write, 0, addr[19:16]}. While the status is held, later traps still pulse trap_irq but leave the status unchanged.
- R9: A data write of any value to index 0xC2 clears the held bit and leaves the other fields in place. If a trap arrives in the same cycle as the clear, that trap is latched.
- R10: An access with acc_valid low, or one outside every enabled window, never raises trap_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Single-cycle access strobe |
| acc_is_mem | input | 1 | 1 = memory access, 0 = I/O access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 20 | Access address (I/O uses bits 15:0) |
| cfg_idx_wr | input | 1 | Load cfg_wdata into the index register |
| cfg_dat_wr | input | 1 | Write cfg_wdata to the indexed register |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Byte at the current index |
| trap_irq | output | 1 | One-cycle interrupt request |

## Verification
Some properties are checked by assertions on every cycle. The request stays quiet while every enable is clear. It never appears without an access in the previous cycle. It stays low for masked slices of the graphics window. Unused indices and the reserved control bits read zero. A held status does not move unless it is cleared. Other behaviour is shown only by the bench's scenarios, against a behavioural model. These are the exact window edges, the port decode that ignores the upper address bits, the byte order of the mask, the packing of the status fields, and a clear that lands in the same cycle as a new trap.

// File: rtl/ldt_pkg.sv
package ldt_pkg;
    localparam int ADDR_W = 20;
    localparam int PORT_W = 16;
    localparam int NMEM   = 3;
    localparam int NIO    = 3;
    localparam int CTL_W  = NMEM + NIO;

    localparam logic [ADDR_W-1:0] MEM_LO [NMEM] = '{20'hA0000, 20'hB0000, 20'hB8000};
    localparam logic [ADDR_W-1:0] MEM_HI [NMEM] = '{20'hAFFFF, 20'hB7FFF, 20'hBFFFF};
    localparam logic [PORT_W-1:0] IO_LO  [NIO]  = '{16'h03B0, 16'h03C0, 16'h03D0};
    localparam logic [PORT_W-1:0] IO_HI  [NIO]  = '{16'h03BF, 16'h03CF, 16'h03DF};

    localparam logic [7:0] IDX_CTL   = 8'hB9;
    localparam logic [7:0] IDX_MASK0 = 8'hBA;
    localparam logic [7:0] IDX_STAT0 = 8'hC0;
    localparam logic [7:0] IDX_STAT1 = 8'hC1;
    localparam logic [7:0] IDX_STAT2 = 8'hC2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              is_mem;
        logic              is_wr;
        logic              valid;
    } trap_stat_t;
endpackage

// File: rtl/ldt_cfg_regs.sv
module ldt_cfg_regs
    import ldt_pkg::*;
#(
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              dat_wr,
    input  logic [7:0]        wdata,
    output logic [7:0]        idx_q,
    output logic [CTL_W-1:0]  ctl_q,
    output logic [MASK_W-1:0] mask_q,
    output logic              stat_clr
);
    localparam int NBYTES = MASK_W / 8;

    typedef struct packed {
        logic [7:0]        idx;
        logic [CTL_W-1:0]  ctl;
        logic [MASK_W-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (idx_wr) begin
            cfg_d.idx = wdata;
        end
        if (dat_wr) begin
            if (cfg_q.idx == IDX_CTL) begin
                cfg_d.ctl = wdata[CTL_W-1:0];
            end
            for (int b = 0; b < NBYTES; b++) begin
                if (cfg_q.idx == 8'(int'(IDX_MASK0) + b)) begin
                    cfg_d.mask[b*8 +: 8] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign idx_q    = cfg_q.idx;
    assign ctl_q    = cfg_q.ctl;
    assign mask_q   = cfg_q.mask;
    assign stat_clr = dat_wr && (cfg_q.idx == IDX_STAT2);
endmodule

// File: rtl/ldt_decode.sv
module ldt_decode
    import ldt_pkg::*;
#(
    parameter int MASK_W = 32
) (
    input  logic              acc_valid,
    input  logic              acc_is_mem,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [CTL_W-1:0]  ctl_q,
    input  logic [MASK_W-1:0] mask_q,
    output logic              hit
);
    localparam int SW        = $clog2(MASK_W);
    localparam int SLICE_LSB = PORT_W - SW;

    logic [NMEM-1:0] mem_hit;
    logic [NIO-1:0]  io_hit;
    logic [SW-1:0]   slice;
    logic [PORT_W-1:0] port;

    assign slice = acc_addr[SLICE_LSB +: SW];
    assign port  = acc_addr[PORT_W-1:0];

    for (genvar g = 0; g < NMEM; g++) begin : g_mem
        logic inside_win;
        assign inside_win = acc_is_mem && (acc_addr >= MEM_LO[g]) && (acc_addr <= MEM_HI[g]);
        if (g == 0) begin : g_masked
            assign mem_hit[g] = inside_win && ctl_q[g] && !mask_q[slice];
        end else begin : g_plain
            assign mem_hit[g] = inside_win && ctl_q[g];
        end
    end

    for (genvar g = 0; g < NIO; g++) begin : g_io
        assign io_hit[g] = !acc_is_mem && (port >= IO_LO[g]) && (port <= IO_HI[g])
                           && ctl_q[NMEM+g];
    end

    assign hit = acc_valid && ((|mem_hit) || (|io_hit));
endmodule

// File: rtl/ldt_status.sv
module ldt_status
    import ldt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_is_mem,
    input  logic              acc_write,
    input  logic              clr,
    output trap_stat_t        stat_q,
    output logic              irq_q
);
    typedef struct packed {
        trap_stat_t stat;
        logic       irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = hit;
        if (clr) begin
            st_d.stat.valid = 1'b0;
        end
        if (hit && !st_d.stat.valid) begin
            st_d.stat.addr   = acc_addr;
            st_d.stat.is_mem = acc_is_mem;
            st_d.stat.is_wr  = acc_write;
            st_d.stat.valid  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_q = st_q.stat;
    assign irq_q  = st_q.irq;
endmodule

// File: rtl/legacy_disp_trap.sv
module legacy_disp_trap
    import ldt_pkg::*;
#(
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_is_mem,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              cfg_idx_wr,
    input  logic              cfg_dat_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              trap_irq
);
    localparam int NBYTES = MASK_W / 8;

    logic [7:0]        idx_q;
    logic [CTL_W-1:0]  ctl_q;
    logic [MASK_W-1:0] mask_q;
    logic              stat_clr;
    logic              hit;
    trap_stat_t        stat_q;

    ldt_cfg_regs #(.MASK_W(MASK_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (cfg_idx_wr),
        .dat_wr   (cfg_dat_wr),
        .wdata    (cfg_wdata),
        .idx_q    (idx_q),
        .ctl_q    (ctl_q),
        .mask_q   (mask_q),
        .stat_clr (stat_clr)
    );

    ldt_decode #(.MASK_W(MASK_W)) u_dec (
        .acc_valid  (acc_valid),
        .acc_is_mem (acc_is_mem),
        .acc_addr   (acc_addr),
        .ctl_q      (ctl_q),
        .mask_q     (mask_q),
        .hit        (hit)
    );

    ldt_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .acc_addr   (acc_addr),
        .acc_is_mem (acc_is_mem),
        .acc_write  (acc_write),
        .clr        (stat_clr),
        .stat_q     (stat_q),
        .irq_q      (trap_irq)
    );

    always_comb begin
        cfg_rdata = 8'h00;
        if (idx_q == IDX_CTL) begin
            cfg_rdata = 8'(ctl_q);
        end
        for (int b = 0; b < NBYTES; b++) begin
            if (idx_q == 8'(int'(IDX_MASK0) + b)) begin
                cfg_rdata = mask_q[b*8 +: 8];
            end
        end
        if (idx_q == IDX_STAT0) begin
            cfg_rdata = stat_q.addr[7:0];
        end
        if (idx_q == IDX_STAT1) begin
            cfg_rdata = stat_q.addr[15:8];
        end
        if (idx_q == IDX_STAT2) begin
            cfg_rdata = {stat_q.valid, stat_q.is_mem, stat_q.is_wr, 1'b0, stat_q.addr[19:16]};
        end
    end
endmodule

// File: rtl/ldt_trap_chk.sv
module ldt_trap_chk
    import ldt_pkg::*;
#(
    parameter int MASK_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_is_mem,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [7:0]        cfg_rdata,
    input logic              trap_irq,
    input logic [7:0]        idx_q,
    input logic [CTL_W-1:0]  ctl_q,
    input logic [MASK_W-1:0] mask_q,
    input trap_stat_t        stat_q,
    input logic              stat_clr
);
    localparam int SW        = $clog2(MASK_W);
    localparam int SLICE_LSB = PORT_W - SW;
    localparam int NBYTES    = MASK_W / 8;

    logic used_idx;
    assign used_idx = ((idx_q >= IDX_CTL) && (idx_q <= 8'(int'(IDX_MASK0) + NBYTES - 1)))
                   || ((idx_q >= IDX_STAT0) && (idx_q <= IDX_STAT2));

    // R10: nothing enabled, nothing raised
    p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q == '0) |=> !trap_irq);

    // R2: a request always follows an access strobe
    p_irq_needs_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_irq |-> $past(acc_valid));

    // R4: masked slice of the graphics window never raises the request
    p_mask_suppress_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_is_mem && (acc_addr[19:16] == 4'hA) && mask_q[acc_addr[SLICE_LSB +: SW]])
        |=> !trap_irq);

    // R7: unused indices read zero
    p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !used_idx |-> (cfg_rdata == 8'h00));

    // R6: reserved control bits read zero
    p_ctl_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == IDX_CTL) |-> (cfg_rdata[7:6] == 2'b00));

    // R8: held status does not move
    p_status_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q.valid && !stat_clr) |=> $stable(stat_q));

    // R9: a clear leaves status empty unless a new trap arrived
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> (!stat_q.valid || trap_irq));
endmodule

bind legacy_disp_trap ldt_trap_chk #(.MASK_W(MASK_W)) chk_i (.*);

// File: tb/legacy_disp_trap_tb_top.sv
`timescale 1ns/1ps
module legacy_disp_trap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_is_mem = 1'b0;
    logic        acc_write = 1'b0;
    logic [19:0] acc_addr = '0;
    logic        cfg_idx_wr = 1'b0;
    logic        cfg_dat_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        trap_irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    legacy_disp_trap dut_i (.*);

    // behavioural reference model
    bit [7:0]  m_ctl, m_idx;
    bit [31:0] m_mask;
    bit [3:0]  m_known;
    bit        m_valid, m_mem, m_wr, m_irq;
    bit [19:0] m_addr;

    function automatic bit exp_hit(bit v, bit mem, int unsigned a);
        int unsigned p;
        if (!v) return 1'b0;
        if (mem) begin
            if (a >= 'hA0000 && a <= 'hAFFFF && m_ctl[0] && !m_mask[(a - 'hA0000) / 2048]) return 1'b1;
            if (a >= 'hB0000 && a <= 'hB7FFF && m_ctl[1]) return 1'b1;
            if (a >= 'hB8000 && a <= 'hBFFFF && m_ctl[2]) return 1'b1;
            return 1'b0;
        end
        p = a % 65536;
        if (p >= 'h3B0 && p <= 'h3BF && m_ctl[3]) return 1'b1;
        if (p >= 'h3C0 && p <= 'h3CF && m_ctl[4]) return 1'b1;
        if (p >= 'h3D0 && p <= 'h3DF && m_ctl[5]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit [7:0] exp_rdata();
        case (m_idx)
            8'hB9: return m_ctl & 8'h3F;
            8'hBA: return m_mask[7:0];
            8'hBB: return m_mask[15:8];
            8'hBC: return m_mask[23:16];
            8'hBD: return m_mask[31:24];
            8'hC0: return m_addr[7:0];
            8'hC1: return m_addr[15:8];
            8'hC2: return {m_valid, m_mem, m_wr, 1'b0, m_addr[19:16]};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        bit h;
        if (!rst_n) begin
            m_ctl = 0; m_idx = 0; m_mask = 0; m_known = 0;
            m_valid = 0; m_mem = 0; m_wr = 0; m_irq = 0; m_addr = 0;
        end else begin
            h = exp_hit(acc_valid, acc_is_mem, 32'(acc_addr));
            if (cfg_dat_wr) begin
                if (m_idx == 8'hB9) m_ctl = cfg_wdata & 8'h3F;
                if (m_idx >= 8'hBA && m_idx <= 8'hBD) begin
                    m_mask[(m_idx - 8'hBA) * 8 +: 8] = cfg_wdata;
                    m_known[m_idx - 8'hBA] = 1'b1;
                end
                if (m_idx == 8'hC2) m_valid = 1'b0;
            end
            if (cfg_idx_wr) m_idx = cfg_wdata;
            if (h && !m_valid) begin
                m_valid = 1'b1; m_mem = acc_is_mem; m_wr = acc_write; m_addr = acc_addr;
            end
            m_irq = h;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            check(trap_irq == m_irq, "R10 cycle compare trap_irq", trap_irq, m_irq);
            if (!(m_idx >= 8'hBA && m_idx <= 8'hBD && !m_known[m_idx - 8'hBA]))
                check(cfg_rdata == exp_rdata(), "R6 cycle compare cfg_rdata", cfg_rdata, exp_rdata());
        end
    end

    task automatic cfg_wr(bit [7:0] idx, bit [7:0] data);
        @(negedge clk); cfg_idx_wr = 1; cfg_wdata = idx;
        @(negedge clk); cfg_idx_wr = 0; cfg_dat_wr = 1; cfg_wdata = data;
        @(negedge clk); cfg_dat_wr = 0;
    endtask

    task automatic cfg_rd(bit [7:0] idx, output bit [7:0] data);
        @(negedge clk); cfg_idx_wr = 1; cfg_wdata = idx;
        @(negedge clk); cfg_idx_wr = 0;
        data = cfg_rdata;
    endtask

    task automatic access(bit mem, bit wr, bit [19:0] a, bit v, output bit irq);
        @(negedge clk); acc_valid = v; acc_is_mem = mem; acc_write = wr; acc_addr = a;
        @(negedge clk); acc_valid = 0;
        irq = trap_irq;
    endtask

    task automatic trap_chk(bit mem, bit [19:0] a, bit exp, string tag);
        bit irq;
        access(mem, 1'b0, a, 1'b1, irq);
        check(irq == exp, tag, irq, exp);
    endtask

    task automatic rd_chk(bit [7:0] idx, bit [7:0] exp, string tag);
        bit [7:0] d;
        cfg_rd(idx, d);
        check(d == exp, tag, d, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit irq;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(trap_irq == 0, "R1 reset trap_irq", trap_irq, 0);
        rd_chk(8'hB9, 8'h00, "R1 reset control");
        rd_chk(8'hC2, 8'h00, "R1 reset status");
        trap_chk(1, 20'hA0000, 0, "R1 no trap after reset");

        // mask defined before use
        cfg_wr(8'hBA, 8'h00); cfg_wr(8'hBB, 8'h00); cfg_wr(8'hBC, 8'h00); cfg_wr(8'hBD, 8'h00);
        cfg_wr(8'hB9, 8'h07);
        trap_chk(1, 20'hA0000, 1, "R2 window A low edge");
        trap_chk(1, 20'hAFFFF, 1, "R2 window A high edge");
        trap_chk(1, 20'hB0000, 1, "R2 window B0 low edge");
        trap_chk(1, 20'hB7FFF, 1, "R2 window B0 high edge");
        trap_chk(1, 20'hB8000, 1, "R2 window B8 low edge");
        trap_chk(1, 20'h9FFFF, 0, "R10 below windows");
        trap_chk(1, 20'hC0000, 0, "R10 above windows");
        access(1, 0, 20'hA1000, 0, irq);
        check(irq == 0, "R10 strobe low", irq, 0);
        @(negedge clk);
        check(trap_irq == 0, "R2 pulse lasts one cycle", trap_irq, 0);

        cfg_wr(8'hB9, 8'hFF);
        rd_chk(8'hB9, 8'h3F, "R6 reserved control bits");
        cfg_wr(8'hB9, 8'h02);
        trap_chk(1, 20'hA0000, 0, "R2 window A disabled");
        trap_chk(1, 20'hB8000, 0, "R2 window B8 disabled");

        cfg_wr(8'hB9, 8'h38);
        trap_chk(0, 20'h003B5, 1, "R3 port 3B window");
        trap_chk(0, 20'h003DF, 1, "R3 port 3D high edge");
        trap_chk(0, 20'h003E0, 0, "R3 port above windows");
        trap_chk(0, 20'h503C4, 1, "R3 upper address bits ignored");
        trap_chk(1, 20'h003C4, 0, "R3 memory access at port address");
        cfg_wr(8'hB9, 8'h10);
        trap_chk(0, 20'h003B0, 0, "R3 port 3B disabled");

        cfg_wr(8'hB9, 8'h01);
        cfg_wr(8'hBA, 8'h01); cfg_wr(8'hBB, 8'h00); cfg_wr(8'hBC, 8'h00); cfg_wr(8'hBD, 8'h80);
        trap_chk(1, 20'hA0000, 0, "R4 slice 0 masked");
        trap_chk(1, 20'hA07FF, 0, "R4 slice 0 top masked");
        trap_chk(1, 20'hA0800, 1, "R4 slice 1 open");
        trap_chk(1, 20'hAF800, 0, "R4 slice 31 masked");
        trap_chk(1, 20'hAF7FF, 1, "R4 slice 30 open");
        cfg_wr(8'hBB, 8'h5A); cfg_wr(8'hBC, 8'hC3);
        rd_chk(8'hBA, 8'h01, "R6 mask byte 0");
        rd_chk(8'hBB, 8'h5A, "R6 mask byte 1");
        rd_chk(8'hBC, 8'hC3, "R6 mask byte 2");
        rd_chk(8'hBD, 8'h80, "R6 mask byte 3");

        cfg_wr(8'hBA, 8'hFF); cfg_wr(8'hBB, 8'hFF); cfg_wr(8'hBC, 8'hFF); cfg_wr(8'hBD, 8'hFF);
        cfg_wr(8'hB9, 8'h06);
        trap_chk(1, 20'hB0000, 1, "R5 mask leaves B0 window");
        trap_chk(1, 20'hBFFFF, 1, "R5 mask leaves B8 window");
        cfg_wr(8'hB9, 8'h08);
        trap_chk(0, 20'h003B0, 1, "R5 mask ignored with no memory enable");
        trap_chk(1, 20'hA0800, 0, "R5 no memory trap with no memory enable");

        // status capture and freeze
        cfg_wr(8'hC2, 8'h00);
        cfg_wr(8'hBA, 8'h00); cfg_wr(8'hBB, 8'h00); cfg_wr(8'hBC, 8'h00); cfg_wr(8'hBD, 8'h00);
        cfg_wr(8'hB9, 8'h11);
        access(1, 1, 20'hA1234, 1, irq);
        check(irq == 1, "R8 write trap", irq, 1);
        rd_chk(8'hC0, 8'h34, "R8 status addr low");
        rd_chk(8'hC1, 8'h12, "R8 status addr mid");
        rd_chk(8'hC2, 8'hEA, "R8 status flags");
        trap_chk(0, 20'h003C0, 1, "R8 later trap still pulses");
        rd_chk(8'hC0, 8'h34, "R8 status frozen");

        // clear, then clear in the same cycle as a trap
        cfg_wr(8'hC2, 8'h00);
        rd_chk(8'hC2, 8'h6A, "R9 clear drops held bit only");
        @(negedge clk); cfg_idx_wr = 1; cfg_wdata = 8'hC2;
        @(negedge clk); cfg_idx_wr = 1; cfg_wdata = 8'hC2;
        // held again from a fresh trap
        cfg_idx_wr = 0;
        access(0, 0, 20'h003C1, 1, irq);
        @(negedge clk);
        cfg_dat_wr = 1; cfg_wdata = 8'h00;
        acc_valid = 1; acc_is_mem = 0; acc_write = 0; acc_addr = 20'h003C5;
        @(negedge clk);
        cfg_dat_wr = 0; acc_valid = 0;
        check(trap_irq == 1, "R9 trap with clear pulses", trap_irq, 1);
        rd_chk(8'hC0, 8'hC5, "R9 same-cycle trap latched low");
        rd_chk(8'hC2, 8'h80, "R9 same-cycle trap latched flags");

        cfg_wr(8'h10, 8'h55);
        rd_chk(8'h10, 8'h00, "R7 unused index reads zero");
        rd_chk(8'hB9, 8'h11, "R7 unused write left control");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule